// File: doc/BRIEF.md
# Two-Wide Register Rename Map with Free List

This block converts the architectural register numbers of up to two instructions per cycle into physical register numbers for an out-of-order core. It holds a speculative map used at dispatch, an architectural map that is updated at commit, and a bit-vector pool of unused physical registers. For each slot in a dispatch group it returns the physical tags of both sources, a freshly allocated tag for the destination, and the mapping that destination had before the group. These outputs feed the scheduler and the reorder buffer.

Instructions that write no register, such as stores and branches, take no tag. Architectural register 0 is hardwired: it is never given a new tag. A group is accepted whole or not at all: when the pool cannot cover every destination in the group, the group stalls. At commit, the committed tag becomes the architectural mapping and the tag it replaced goes back to the pool. A flush rolls the speculative map back to the architectural map and rebuilds the pool from the architectural map. This removes every tag that was allocated on the wrong path.

Top module: `rn_map_top`

## Requirements
- R1: After reset both maps send architectural register i to physical register i, and the pool holds exactly the physical registers numbered NUM_ARCH and above.
- R2: Each source index is translated through the speculative map as it stands at the start of the cycle, and the result is shown combinationally on the rename outputs.
- R3: An allocating slot gets the lowest-numbered free physical register, with slot 0 taking precedence over slot 1. Its old-mapping output shows the speculative entry of its destination.
- R4: `dsp_ready` is low when the pool holds fewer registers than the group needs. While it is low the group takes nothing and leaves both the map and the pool unchanged.
- R5: A slot-1 source that names the destination of an allocating slot 0 receives slot 0's new tag in place of the map entry.
- R6: If both slots write the same destination, the map keeps slot 1's tag, and slot 1's old-mapping output is slot 0's new tag.
- R7: A destination of 0 allocates nothing, and both its new-tag and old-mapping outputs read 0. A commit to architectural register 0 is ignored.
- R8: A slot whose valid bit or write-enable bit is 0 consumes no register. Its new-tag and old-mapping outputs read 0.
- R9: A commit writes its new tag into the architectural map and returns its old tag to the pool. The returned tag can be allocated from the next cycle on.
- R10: During `flush`, `dsp_ready` is low and dispatch is ignored. Commits presented in the same cycle are applied first. The speculative map then becomes the resulting architectural map, and the pool becomes every physical register that map does not reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Roll the speculative state back to the committed state |
| dsp_valid | input | 2 | Per-slot instruction valid |
| dsp_wr | input | 2 | Per-slot destination write enable |
| dsp_rs1 | input | 2x AW | Per-slot first source architectural index |
| dsp_rs2 | input | 2x AW | Per-slot second source architectural index |
| dsp_rd | input | 2x AW | Per-slot destination architectural index |
| dsp_ready | output | 1 | The group is accepted this cycle |
| ren_ps1 | output | 2x PW | Per-slot first source physical tag |
| ren_ps2 | output | 2x PW | Per-slot second source physical tag |
| ren_pd | output | 2x PW | Per-slot newly allocated destination tag |
| ren_pold | output | 2x PW | Per-slot previous mapping of the destination |
| cmt_valid | input | 2 | Per-slot commit valid |
| cmt_rd | input | 2x AW | Committed destination architectural index |
| cmt_pnew | input | 2x PW | Tag that becomes the architectural mapping |
| cmt_pold | input | 2x PW | Tag released to the pool |

## Verification
Commit and flush can arrive in the same cycle. In that case the rolled-back map and the rebuilt pool must already include the commit. The bench provokes this by raising a commit together with a flush while a dispatch group is also offered. It then judges the result through later lookups, which must return the committed tag, and through later allocations, which must draw from the rebuilt pool lowest number first. A second overlap is a commit that returns a register in a cycle when the pool is empty. The bench shows that the stall lifts only in the following cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_SLOTS    = 2;
    localparam int RN_ARCH_DEF = 8;
    localparam int RN_PHYS_DEF = 16;
endpackage

// File: rtl/rn_free_pick.sv
// Picks the two lowest free physical registers and counts the pool.
module rn_free_pick #(
    parameter int NP = 16,
    parameter int PW = 4,
    parameter int CW = 5
) (
    input  logic [NP-1:0] free_vec,
    output logic [PW-1:0] pick_a,
    output logic [PW-1:0] pick_b,
    output logic [CW-1:0] free_cnt
);
    function automatic logic [PW-1:0] lowest(input logic [NP-1:0] v);
        logic [PW-1:0] r;
        r = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (v[i]) r = PW'(i);
        end
        return r;
    endfunction

    logic [NP-1:0] rest_vec;

    always_comb begin
        pick_a   = lowest(free_vec);
        rest_vec = free_vec & ~(NP'(1) << pick_a);
        pick_b   = lowest(rest_vec);
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NP; i++) begin
            free_cnt = free_cnt + CW'(free_vec[i]);
        end
    end
endmodule

// File: rtl/rn_group_dep.sv
// Resolves slot-1 sources and old mapping against slot 0 of the same group.
module rn_group_dep #(
    parameter int AW = 3,
    parameter int PW = 4
) (
    input  logic                  s0_alloc,
    input  logic [AW-1:0]         s0_rd,
    input  logic [PW-1:0]         s0_pd,
    input  logic [1:0][AW-1:0]    s1_rs,
    input  logic [1:0][PW-1:0]    s1_rs_map,
    input  logic                  s1_alloc,
    input  logic [AW-1:0]         s1_rd,
    input  logic [PW-1:0]         s1_rd_map,
    output logic [1:0][PW-1:0]    s1_ps,
    output logic [PW-1:0]         s1_pold
);
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_src
            logic hit;
            assign hit      = s0_alloc && (s1_rs[g] == s0_rd);
            assign s1_ps[g] = hit ? s0_pd : s1_rs_map[g];
        end
    endgenerate

    always_comb begin
        if (!s1_alloc)
            s1_pold = '0;
        else if (s0_alloc && (s1_rd == s0_rd))
            s1_pold = s0_pd;
        else
            s1_pold = s1_rd_map;
    end
endmodule

// File: rtl/rn_map_top.sv
module rn_map_top
    import rn_pkg::*;
#(
    parameter int NA = RN_ARCH_DEF,
    parameter int NP = RN_PHYS_DEF,
    parameter int AW = $clog2(NA),
    parameter int PW = $clog2(NP)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [RN_SLOTS-1:0]         dsp_valid,
    input  logic [RN_SLOTS-1:0]         dsp_wr,
    input  logic [RN_SLOTS-1:0][AW-1:0] dsp_rs1,
    input  logic [RN_SLOTS-1:0][AW-1:0] dsp_rs2,
    input  logic [RN_SLOTS-1:0][AW-1:0] dsp_rd,
    output logic                        dsp_ready,
    output logic [RN_SLOTS-1:0][PW-1:0] ren_ps1,
    output logic [RN_SLOTS-1:0][PW-1:0] ren_ps2,
    output logic [RN_SLOTS-1:0][PW-1:0] ren_pd,
    output logic [RN_SLOTS-1:0][PW-1:0] ren_pold,
    input  logic [RN_SLOTS-1:0]         cmt_valid,
    input  logic [RN_SLOTS-1:0][AW-1:0] cmt_rd,
    input  logic [RN_SLOTS-1:0][PW-1:0] cmt_pnew,
    input  logic [RN_SLOTS-1:0][PW-1:0] cmt_pold
);
    localparam int CW = $clog2(NP + 1);

    typedef logic [NA-1:0][PW-1:0] map_t;

    typedef struct packed {
        map_t          spec;
        map_t          arch;
        logic [NP-1:0] free;
    } state_t;

    function automatic state_t init_state();
        state_t s;
        for (int i = 0; i < NA; i++) begin
            s.spec[i] = PW'(i);
            s.arch[i] = PW'(i);
        end
        for (int j = 0; j < NP; j++) begin
            s.free[j] = (j >= NA);
        end
        return s;
    endfunction

    localparam state_t RST_STATE = init_state();

    state_t st_q, st_d;

    map_t          spec_q, arch_q;
    logic [NP-1:0] free_q;
    assign spec_q = st_q.spec;
    assign arch_q = st_q.arch;
    assign free_q = st_q.free;

    // ---- allocation demand ----
    logic [RN_SLOTS-1:0] alloc;
    logic [1:0]          need;
    genvar k;
    generate
        for (k = 0; k < RN_SLOTS; k++) begin : g_need
            assign alloc[k] = dsp_valid[k] && dsp_wr[k] && (dsp_rd[k] != '0);
        end
    endgenerate
    assign need = 2'(alloc[0]) + 2'(alloc[1]);

    // ---- free pool pick ----
    logic [PW-1:0] pick_a, pick_b;
    logic [CW-1:0] free_cnt;

    rn_free_pick #(.NP(NP), .PW(PW), .CW(CW)) u_pick (
        .free_vec (free_q),
        .pick_a   (pick_a),
        .pick_b   (pick_b),
        .free_cnt (free_cnt)
    );

    assign dsp_ready = !flush && (CW'(need) <= free_cnt);

    // ---- slot 0 rename ----
    logic [PW-1:0] pd0, pd1;
    assign pd0 = alloc[0] ? pick_a : '0;
    assign pd1 = alloc[1] ? (alloc[0] ? pick_b : pick_a) : '0;

    assign ren_ps1[0]  = spec_q[dsp_rs1[0]];
    assign ren_ps2[0]  = spec_q[dsp_rs2[0]];
    assign ren_pd[0]   = pd0;
    assign ren_pold[0] = alloc[0] ? spec_q[dsp_rd[0]] : '0;
    assign ren_pd[1]   = pd1;

    // ---- slot 1 rename with in-group dependence ----
    logic [1:0][AW-1:0] s1_rs;
    logic [1:0][PW-1:0] s1_rs_map;
    logic [1:0][PW-1:0] s1_ps;
    logic [PW-1:0]      s1_pold;

    assign s1_rs[0]     = dsp_rs1[1];
    assign s1_rs[1]     = dsp_rs2[1];
    assign s1_rs_map[0] = spec_q[dsp_rs1[1]];
    assign s1_rs_map[1] = spec_q[dsp_rs2[1]];

    rn_group_dep #(.AW(AW), .PW(PW)) u_dep (
        .s0_alloc  (alloc[0]),
        .s0_rd     (dsp_rd[0]),
        .s0_pd     (pd0),
        .s1_rs     (s1_rs),
        .s1_rs_map (s1_rs_map),
        .s1_alloc  (alloc[1]),
        .s1_rd     (dsp_rd[1]),
        .s1_rd_map (spec_q[dsp_rd[1]]),
        .s1_ps     (s1_ps),
        .s1_pold   (s1_pold)
    );

    assign ren_ps1[1]  = s1_ps[0];
    assign ren_ps2[1]  = s1_ps[1];
    assign ren_pold[1] = s1_pold;

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        // commits first; a later slot overrides an earlier one on the same index
        for (int c = 0; c < RN_SLOTS; c++) begin
            if (cmt_valid[c] && (cmt_rd[c] != '0)) begin
                st_d.arch[cmt_rd[c]] = cmt_pnew[c];
                if (cmt_pold[c] != '0)
                    st_d.free[cmt_pold[c]] = 1'b1;
            end
        end
        if (flush) begin
            st_d.spec = st_d.arch;
            st_d.free = '1;
            for (int a = 0; a < NA; a++) begin
                st_d.free[st_d.arch[a]] = 1'b0;
            end
        end else if (dsp_ready) begin
            for (int s = 0; s < RN_SLOTS; s++) begin
                if (alloc[s]) begin
                    st_d.spec[dsp_rd[s]] = ren_pd[s];
                    st_d.free[ren_pd[s]] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= RST_STATE;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/rn_map_chk.sv
module rn_map_chk #(
    parameter int NA = 8,
    parameter int NP = 16,
    parameter int AW = 3,
    parameter int PW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic [1:0]           dsp_valid,
    input logic [1:0]           dsp_wr,
    input logic [1:0][AW-1:0]   dsp_rs1,
    input logic [1:0][AW-1:0]   dsp_rd,
    input logic                 dsp_ready,
    input logic [1:0][PW-1:0]   ren_ps1,
    input logic [1:0][PW-1:0]   ren_pd,
    input logic [NA-1:0][PW-1:0] spec_q,
    input logic [NA-1:0][PW-1:0] arch_q,
    input logic [NP-1:0]        free_q
);
    logic a0, a1;
    assign a0 = dsp_valid[0] && dsp_wr[0] && (dsp_rd[0] != '0);
    assign a1 = dsp_valid[1] && dsp_wr[1] && (dsp_rd[1] != '0);

    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_ready && a0) |-> free_q[ren_pd[0]]);

    p_two_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_ready && a0 && a1) |-> (ren_pd[0] != ren_pd[1]));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_ready && !flush) |=> $stable(spec_q));

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid[1] && a0 && (dsp_rs1[1] == dsp_rd[0])) |-> (ren_ps1[1] == ren_pd[0]));

    p_zero_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q[0] == 1'b0) && (spec_q[0] == '0) && (arch_q[0] == '0));

    p_flush_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (spec_q == arch_q));
endmodule

bind rn_map_top rn_map_chk #(.NA(NA), .NP(NP), .AW(AW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .dsp_valid (dsp_valid),
    .dsp_wr    (dsp_wr),
    .dsp_rs1   (dsp_rs1),
    .dsp_rd    (dsp_rd),
    .dsp_ready (dsp_ready),
    .ren_ps1   (ren_ps1),
    .ren_pd    (ren_pd),
    .spec_q    (spec_q),
    .arch_q    (arch_q),
    .free_q    (free_q)
);

// File: tb/sim_rn_map_top.sv
module sim_rn_map_top;
    localparam int PERIOD = 10;
    localparam int AW = 3;
    localparam int PW = 4;

    logic clk = 0, rst_n = 0, flush = 0;
    logic [1:0] dsp_valid = 0, dsp_wr = 0, cmt_valid = 0;
    logic [1:0][AW-1:0] dsp_rs1 = '0, dsp_rs2 = '0, dsp_rd = '0, cmt_rd = '0;
    logic [1:0][PW-1:0] cmt_pnew = '0, cmt_pold = '0;
    logic dsp_ready;
    logic [1:0][PW-1:0] ren_ps1, ren_ps2, ren_pd, ren_pold;

    always #(PERIOD/2) clk = ~clk;

    rn_map_top u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .dsp_valid(dsp_valid), .dsp_wr(dsp_wr),
        .dsp_rs1(dsp_rs1), .dsp_rs2(dsp_rs2), .dsp_rd(dsp_rd),
        .dsp_ready(dsp_ready),
        .ren_ps1(ren_ps1), .ren_ps2(ren_ps2), .ren_pd(ren_pd), .ren_pold(ren_pold),
        .cmt_valid(cmt_valid), .cmt_rd(cmt_rd), .cmt_pnew(cmt_pnew), .cmt_pold(cmt_pold)
    );

    int total = 0, bad = 0;
    logic done = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0] vld; logic [1:0] wr;
        logic [3:0] a0, b0, d0, a1, b1, d1;
        logic [3:0] pa0, pb0, pd0, po0, pa1, pb1, pd1, po1;
    } vec_t;

    // Walk from reset: pool 8..15 handed out lowest first
    localparam vec_t TBL [5] = '{
        // R3 R5: slot1 reads slot0's destination
        '{2'b11, 2'b11, 4'd1, 4'd2, 4'd3, 4'd3, 4'd4, 4'd5,
          4'd1, 4'd2, 4'd8, 4'd3, 4'd8, 4'd4, 4'd9, 4'd5},
        // R6: both write r3
        '{2'b11, 2'b11, 4'd3, 4'd5, 4'd3, 4'd3, 4'd0, 4'd3,
          4'd8, 4'd9, 4'd10, 4'd8, 4'd10, 4'd0, 4'd11, 4'd10},
        // R7 R8: rd=0 and a non-writing slot allocate nothing
        '{2'b11, 2'b01, 4'd3, 4'd6, 4'd0, 4'd5, 4'd7, 4'd2,
          4'd11, 4'd6, 4'd0, 4'd0, 4'd9, 4'd7, 4'd0, 4'd0},
        // R8: invalid slot1
        '{2'b01, 2'b11, 4'd3, 4'd3, 4'd7, 4'd0, 4'd0, 4'd6,
          4'd11, 4'd11, 4'd12, 4'd7, 4'd0, 4'd0, 4'd0, 4'd0},
        // R2 R5
        '{2'b11, 2'b11, 4'd0, 4'd0, 4'd1, 4'd1, 4'd0, 4'd2,
          4'd0, 4'd0, 4'd13, 4'd1, 4'd13, 4'd0, 4'd14, 4'd2}
    };

    task automatic drive(input logic [1:0] v, input logic [1:0] w,
                         input int a0, input int b0, input int d0,
                         input int a1, input int b1, input int d1);
        dsp_valid = v; dsp_wr = w;
        dsp_rs1[0] = AW'(a0); dsp_rs2[0] = AW'(b0); dsp_rd[0] = AW'(d0);
        dsp_rs1[1] = AW'(a1); dsp_rs2[1] = AW'(b1); dsp_rd[1] = AW'(d1);
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: identity map, pool starts at 8
        @(negedge clk);
        drive(2'b01, 2'b01, 5, 6, 2, 0, 0, 0); #1;
        chk("R1 lookup rs1", ren_ps1[0], 5);
        chk("R1 lookup rs2", ren_ps2[0], 6);
        chk("R1 ready", dsp_ready, 1);
        chk("R1 first free", ren_pd[0], 8);
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0);

        // R2 R3 R5 R6 R7 R8 table walk
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            drive(TBL[i].vld, TBL[i].wr, TBL[i].a0, TBL[i].b0, TBL[i].d0,
                  TBL[i].a1, TBL[i].b1, TBL[i].d1);
            #1;
            chk("R4 table ready", dsp_ready, 1);
            chk("R2 s0 ps1", ren_ps1[0], TBL[i].pa0);
            chk("R2 s0 ps2", ren_ps2[0], TBL[i].pb0);
            chk("R3 s0 pd", ren_pd[0], TBL[i].pd0);
            chk("R3 s0 pold", ren_pold[0], TBL[i].po0);
            chk("R5 s1 ps1", ren_ps1[1], TBL[i].pa1);
            chk("R5 s1 ps2", ren_ps2[1], TBL[i].pb1);
            chk("R3 s1 pd", ren_pd[1], TBL[i].pd1);
            chk("R6 s1 pold", ren_pold[1], TBL[i].po1);
        end
        // R6: map kept slot1's tag for r3 (11)
        @(negedge clk);
        drive(2'b01, 2'b00, 3, 5, 0, 0, 0, 0); #1;
        chk("R6 r3 maps to later tag", ren_ps1[0], 11);
        chk("R2 r5 lookup", ren_ps2[0], 9);

        // R4: only 15 left, group needs two
        @(negedge clk);
        drive(2'b11, 2'b11, 0, 0, 4, 0, 0, 6); #1;
        chk("R4 stall", dsp_ready, 0);
        @(negedge clk); #1;
        chk("R4 still stalled", dsp_ready, 0);
        drive(2'b01, 2'b01, 4, 0, 4, 0, 0, 0); #1;
        chk("R4 nothing consumed, ready", dsp_ready, 1);
        chk("R4 nothing consumed, pd", ren_pd[0], 15);
        chk("R4 nothing consumed, map", ren_ps1[0], 4);
        chk("R3 pold r4", ren_pold[0], 4);
        @(negedge clk);
        drive(2'b01, 2'b00, 0, 0, 6, 0, 0, 0); #1;
        chk("R8 empty pool, no need", dsp_ready, 1);
        drive(2'b01, 2'b01, 0, 0, 6, 0, 0, 0); #1;
        chk("R4 empty pool stalls", dsp_ready, 0);

        // R9: commit r3 -> 8, release 3
        cmt_valid = 2'b01; cmt_rd[0] = 3; cmt_pnew[0] = 8; cmt_pold[0] = 3; #1;
        chk("R9 not yet free", dsp_ready, 0);
        @(negedge clk);
        cmt_valid = 0; #1;
        chk("R9 freed next cycle", dsp_ready, 1);
        chk("R9 freed tag reused", ren_pd[0], 3);
        chk("R3 pold r6", ren_pold[0], 6);

        // R7: commit to r0 ignored
        @(negedge clk);
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
        cmt_valid = 2'b01; cmt_rd[0] = 0; cmt_pnew[0] = 9; cmt_pold[0] = 5;
        @(negedge clk);
        cmt_valid = 0;
        drive(2'b01, 2'b01, 0, 0, 2, 0, 0, 0); #1;
        chk("R7 r0 commit frees nothing", dsp_ready, 0);

        // R10: flush with same-cycle commit of r1 -> 13
        @(negedge clk);
        flush = 1;
        cmt_valid = 2'b10; cmt_rd[1] = 1; cmt_pnew[1] = 13; cmt_pold[1] = 1;
        drive(2'b01, 2'b01, 0, 0, 5, 0, 0, 0); #1;
        chk("R10 ready low in flush", dsp_ready, 0);
        @(negedge clk);
        flush = 0; cmt_valid = 0;
        drive(2'b11, 2'b11, 3, 1, 5, 6, 7, 5); #1;
        chk("R10 r3 restored", ren_ps1[0], 8);
        chk("R10 same-cycle commit seen", ren_ps2[0], 13);
        chk("R10 r6 rolled back", ren_ps1[1], 6);
        chk("R10 r7", ren_ps2[1], 7);
        chk("R10 pool rebuilt s0", ren_pd[0], 1);
        chk("R10 pool rebuilt s1", ren_pd[1], 3);
        chk("R10 s0 pold", ren_pold[0], 5);
        chk("R6 s1 pold after flush", ren_pold[1], 1);
        chk("R10 ready", dsp_ready, 1);
        @(negedge clk);
        drive(2'b01, 2'b01, 5, 0, 2, 0, 0, 0); #1;
        chk("R6 later tag in map", ren_ps1[0], 3);
        chk("R10 next free is 9", ren_pd[0], 9);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule